// File: doc/BRIEF.md
# Flash Bad-Block Table Manager

This block keeps a one-bit-per-block map of the unusable blocks in a NAND flash array. Once reset is released it walks the block addresses from zero upward. For each address it asks a simple request/acknowledge flash port whether that block carries a bad-block marker, and it records the answer in the map. While this walk is running, program and erase requests from the rest of the system are refused.

After the walk, the map grows at run time. A block whose program or erase status read reports a failure is reported on a fail input and is marked bad. A rebuild request repeats the walk and rewrites every entry from the markers held in the array. A failure report that arrives while a walk is running is held in a small queue and is applied once the walk has finished, so it is not lost. Any block can be looked up at any time through a combinational query port.

Top module: `badblk_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `scan_done` is 0, `mrd_req` is 1, `mrd_blk` is 0 and every map entry reads 0.
- R2: When a marker read for block N is acknowledged with `mrd_mark`=1, entry N reads 1 from the next cycle on. An acknowledge with `mrd_mark`=0 leaves entry N at 0.
- R3: Only one marker read is outstanding at a time. `mrd_req` and `mrd_blk` hold until `mrd_ack`, and after each acknowledge below the last block, `mrd_blk` steps up by one.
- R4: `scan_done` rises, and `mrd_req` falls, in the cycle after the acknowledge for block NB-1.
- R5: `pe_grant` equals `pe_req` while `scan_done` is 1 and is 0 whenever `scan_done` is 0.
- R6: A `sfail_vld` pulse for block B while `scan_done` is 1 makes entry B read 1 from the next cycle on.
- R7: A `rebuild_req` pulse while `scan_done` is 1 drops `scan_done` and restarts the walk at block 0. Every entry is then rewritten from the markers, so an entry that was set only by an earlier failure report reads 0 if its marker is clear.
- R8: Failure reports that arrive while a walk is running (up to QD of them) are queued. They are applied in arrival order, one per cycle, once `scan_done` is 1, and they survive the rewrite done by that walk.
- R9: A `rebuild_req` pulse while a walk is running has no effect: the walk carries on from its current block.
- R10: `q_bad` shows the map entry addressed by `q_blk` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrd_req | output | 1 | Marker read request to the flash port |
| mrd_blk | output | AW | Block address of the marker read |
| mrd_ack | input | 1 | Flash port answer strobe |
| mrd_mark | input | 1 | Marker found, valid with `mrd_ack` |
| sfail_vld | input | 1 | Program/erase status failure report |
| sfail_blk | input | AW | Block that failed |
| rebuild_req | input | 1 | Request to rewrite the map from the array |
| pe_req | input | 1 | Program/erase request from the system |
| pe_grant | output | 1 | Program/erase permission |
| scan_done | output | 1 | Map is complete and no walk is running |
| q_blk | input | AW | Lookup address |
| q_bad | output | 1 | Map entry at `q_blk` |

## Verification
The bench builds the block with NB=16 and QD=4. With these values a full walk takes only a few dozen cycles, so the first walk, a rebuild, and the reads of the first and last block all fit in one short run. The flash responder answers after a latency that varies with the address, which keeps request and address held across several waiting cycles. During the rebuild the bench fills the failure queue to its full depth of four and then checks that every entry lands after the walk ends.

// File: rtl/badblk_pkg.sv
package badblk_pkg;
   typedef enum logic {
      PH_WALK  = 1'b0,
      PH_READY = 1'b1
   } phase_t;
endpackage

// File: rtl/badblk_scan_seq.sv
module badblk_scan_seq
   import badblk_pkg::*;
#(
   parameter int NB = 2048,
   parameter int AW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rebuild_req,
   input  logic          mrd_ack,
   input  logic          mrd_mark,
   output logic          mrd_req,
   output logic [AW-1:0] mrd_blk,
   output logic          scan_done,
   output logic          wr_en,
   output logic [AW-1:0] wr_blk,
   output logic          wr_val
);
   localparam logic [AW-1:0] LAST_BLK = AW'(NB - 1);

   phase_t        phase;
   logic [AW-1:0] cur_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_WALK;
         cur_blk <= '0;
      end else begin
         unique case (phase)
            PH_WALK: begin
               if (mrd_ack) begin
                  if (cur_blk == LAST_BLK) phase <= PH_READY;
                  else                     cur_blk <= cur_blk + AW'(1);
               end
            end
            PH_READY: begin
               if (rebuild_req) begin
                  phase   <= PH_WALK;
                  cur_blk <= '0;
               end
            end
            default: phase <= PH_WALK;
         endcase
      end
   end

   assign mrd_req   = (phase == PH_WALK);
   assign scan_done = (phase == PH_READY);
   assign mrd_blk   = cur_blk;
   assign wr_en     = mrd_req && mrd_ack;
   assign wr_blk    = cur_blk;
   assign wr_val    = mrd_mark;
endmodule

// File: rtl/badblk_fail_fifo.sv
module badblk_fail_fifo #(
   parameter int AW = 11,
   parameter int QD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_blk,
   input  logic          pop,
   output logic          nonempty,
   output logic [AW-1:0] head_blk
);
   generate
      if (QD == 1) begin : g_single
         logic          held;
         logic [AW-1:0] held_blk;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held     <= 1'b0;
               held_blk <= '0;
            end else if (push) begin
               held     <= 1'b1;
               held_blk <= push_blk;
            end else if (pop) begin
               held     <= 1'b0;
            end
         end
         assign nonempty = held;
         assign head_blk = held_blk;
      end else begin : g_ring
         localparam int PW = $clog2(QD);
         localparam int CW = $clog2(QD + 1);
         logic [AW-1:0] slot [QD];
         logic [PW-1:0] wr_ptr, rd_ptr;
         logic [CW-1:0] fill;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               fill   <= '0;
            end else begin
               if (push) begin
                  slot[wr_ptr] <= push_blk;
                  wr_ptr       <= wr_ptr + PW'(1);
               end
               if (pop && fill != '0) rd_ptr <= rd_ptr + PW'(1);
               if (push && !(pop && fill != '0))      fill <= fill + CW'(1);
               else if (!push && pop && fill != '0)   fill <= fill - CW'(1);
            end
         end
         assign nonempty = (fill != '0);
         assign head_blk = slot[rd_ptr];
      end
   endgenerate
endmodule

// File: rtl/badblk_bitmap.sv
module badblk_bitmap #(
   parameter int NB = 2048,
   parameter int AW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_blk,
   input  logic          wr_val,
   input  logic          set_a,
   input  logic [AW-1:0] set_a_blk,
   input  logic          set_b,
   input  logic [AW-1:0] set_b_blk,
   input  logic [AW-1:0] rd_blk,
   output logic          rd_bad,
   output logic [NB-1:0] bits
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits <= '0;
      end else begin
         if (wr_en) bits[wr_blk]    <= wr_val;
         if (set_a) bits[set_a_blk] <= 1'b1;
         if (set_b) bits[set_b_blk] <= 1'b1;
      end
   end

   assign rd_bad = bits[rd_blk];
endmodule

// File: rtl/badblk_tracker.sv
module badblk_tracker #(
   parameter int NB = 2048,
   parameter int QD = 4,
   localparam int AW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          mrd_req,
   output logic [AW-1:0] mrd_blk,
   input  logic          mrd_ack,
   input  logic          mrd_mark,
   input  logic          sfail_vld,
   input  logic [AW-1:0] sfail_blk,
   input  logic          rebuild_req,
   input  logic          pe_req,
   output logic          pe_grant,
   output logic          scan_done,
   input  logic [AW-1:0] q_blk,
   output logic          q_bad
);
   generate
      if (NB < 2) begin : g_nb_chk
         $error("badblk_tracker: NB must be at least 2");
      end
      if (QD < 1 || (QD & (QD - 1)) != 0) begin : g_qd_chk
         $error("badblk_tracker: QD must be a power of two");
      end
   endgenerate

   logic          wr_en, wr_val;
   logic [AW-1:0] wr_blk;
   logic          q_nonempty;
   logic [AW-1:0] q_head;
   logic [NB-1:0] tbl_bits;

   badblk_scan_seq #(.NB(NB), .AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rebuild_req(rebuild_req),
      .mrd_ack    (mrd_ack),
      .mrd_mark   (mrd_mark),
      .mrd_req    (mrd_req),
      .mrd_blk    (mrd_blk),
      .scan_done  (scan_done),
      .wr_en      (wr_en),
      .wr_blk     (wr_blk),
      .wr_val     (wr_val)
   );

   badblk_fail_fifo #(.AW(AW), .QD(QD)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (sfail_vld && !scan_done),
      .push_blk(sfail_blk),
      .pop     (scan_done && q_nonempty),
      .nonempty(q_nonempty),
      .head_blk(q_head)
   );

   badblk_bitmap #(.NB(NB), .AW(AW)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_blk   (wr_blk),
      .wr_val   (wr_val),
      .set_a    (sfail_vld && scan_done),
      .set_a_blk(sfail_blk),
      .set_b    (scan_done && q_nonempty),
      .set_b_blk(q_head),
      .rd_blk   (q_blk),
      .rd_bad   (q_bad),
      .bits     (tbl_bits)
   );

   assign pe_grant = pe_req && scan_done;
endmodule

// File: rtl/badblk_tracker_chk.sv
module badblk_tracker_chk #(
   parameter int NB = 2048,
   parameter int AW = $clog2(NB)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mrd_req,
   input logic [AW-1:0] mrd_blk,
   input logic          mrd_ack,
   input logic          sfail_vld,
   input logic [AW-1:0] sfail_blk,
   input logic          pe_grant,
   input logic          scan_done,
   input logic [NB-1:0] tbl_bits
);
   localparam logic [AW-1:0] LAST_BLK = AW'(NB - 1);

   // R5
   no_early_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_done |-> !pe_grant);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_blk)));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_req && mrd_ack && mrd_blk != LAST_BLK) |=> (mrd_blk == $past(mrd_blk) + AW'(1)));

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_req && mrd_ack && mrd_blk == LAST_BLK) |=> (scan_done && !mrd_req));

   // R6
   fail_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && sfail_vld) |=> tbl_bits[$past(sfail_blk)]);
endmodule

bind badblk_tracker badblk_tracker_chk #(.NB(NB), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mrd_req  (mrd_req),
   .mrd_blk  (mrd_blk),
   .mrd_ack  (mrd_ack),
   .sfail_vld(sfail_vld),
   .sfail_blk(sfail_blk),
   .pe_grant (pe_grant),
   .scan_done(scan_done),
   .tbl_bits (tbl_bits)
);

// File: tb/badblk_tracker_test.sv
module badblk_tracker_test;
   localparam int NB = 16;
   localparam int QD = 4;
   localparam int AW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          mrd_req, mrd_ack = 1'b0, mrd_mark = 1'b0;
   logic [AW-1:0] mrd_blk;
   logic          sfail_vld = 1'b0, rebuild_req = 1'b0, pe_req = 1'b0;
   logic [AW-1:0] sfail_blk = '0, q_blk = '0;
   logic          pe_grant, scan_done, q_bad;

   badblk_tracker #(.NB(NB), .QD(QD)) uut (
      .clk(clk), .rst_n(rst_n), .mrd_req(mrd_req), .mrd_blk(mrd_blk),
      .mrd_ack(mrd_ack), .mrd_mark(mrd_mark), .sfail_vld(sfail_vld),
      .sfail_blk(sfail_blk), .rebuild_req(rebuild_req), .pe_req(pe_req),
      .pe_grant(pe_grant), .scan_done(scan_done), .q_blk(q_blk), .q_bad(q_bad)
   );

   int    vecs = 0, miss = 0;
   string ptag = "";
   bit    marks [NB];
   int    seed = 0;

   task automatic chk(string tag, string what, int act, int exp);
      vecs++;
      if (act != exp) begin
         miss++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // flash responder: answers after an address-dependent wait
   int wait_cnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         mrd_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mrd_ack) begin
         mrd_ack <= 1'b0;
      end else if (mrd_req) begin
         if (wait_cnt >= (int'(mrd_blk) * 7 + seed) % 3) begin
            mrd_ack  <= 1'b1;
            mrd_mark <= marks[mrd_blk];
            wait_cnt <= 0;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // behavioural reference model
   bit m_tbl [NB];
   bit m_done;
   int m_a;
   int fq[$];
   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_tbl[i]) m_tbl[i] = 1'b0;
         m_done = 1'b0;
         m_a    = 0;
         fq.delete();
      end else begin
         bit pre_done;
         pre_done = m_done;
         if (!pre_done && mrd_ack) begin
            m_tbl[m_a] = mrd_mark;
            if (m_a == NB - 1) m_done = 1'b1;
            else               m_a = m_a + 1;
         end
         if (sfail_vld) begin
            if (!pre_done) fq.push_back(int'(sfail_blk));
            else           m_tbl[sfail_blk] = 1'b1;
         end
         if (pre_done && fq.size() > 0) m_tbl[fq.pop_front()] = 1'b1;
         if (pre_done && rebuild_req) begin
            m_done = 1'b0;
            m_a    = 0;
         end
      end
   end

   // per-cycle comparison, away from the clock edges
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         chk({"R4 ", ptag}, "scan_done", int'(scan_done), int'(m_done));
         chk({"R3 ", ptag}, "mrd_req",   int'(mrd_req),   int'(!m_done));
         chk({"R3 ", ptag}, "mrd_blk",   int'(mrd_blk),   m_a);
         chk({"R5 ", ptag}, "pe_grant",  int'(pe_grant),  int'(pe_req && m_done));
         chk({"R10 ", ptag}, "q_bad",    int'(q_bad),     int'(m_tbl[q_blk]));
      end
   end

   task automatic wait_done();
      while (!scan_done) @(negedge clk);
   endtask

   task automatic peek(int blk, int exp, string tag);
      @(negedge clk);
      q_blk = AW'(blk);
      #1;
      chk(tag, $sformatf("entry %0d", blk), int'(q_bad), exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miss++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin : stimulus
      int b;
      foreach (marks[i]) marks[i] = (i == 0 || i == 3 || i == 7 || i == 15);
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "scan_done in reset", int'(scan_done), 0);
      chk("R1", "entry 0 in reset", int'(q_bad), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "scan_done", int'(scan_done), 0);
      chk("R1", "mrd_req", int'(mrd_req), 1);
      chk("R1", "mrd_blk", int'(mrd_blk), 0);

      // failures during the first walk are queued; grant must stay low
      pe_req = 1'b1;
      ptag = "R8";
      @(negedge clk); sfail_vld = 1'b1; sfail_blk = 4'd5;
      @(negedge clk); sfail_blk = 4'd9;
      @(negedge clk); sfail_vld = 1'b0;
      #1;
      chk("R5", "pe_grant mid-walk", int'(pe_grant), 0);

      // rebuild request in the middle of the walk is ignored
      while (mrd_blk < 4'd6) @(negedge clk);
      ptag = "R9";
      b = int'(mrd_blk);
      rebuild_req = 1'b1;
      @(negedge clk);
      rebuild_req = 1'b0;
      #1;
      chk("R9", "walk kept its place", int'(int'(mrd_blk) >= b), 1);
      chk("R9", "scan_done", int'(scan_done), 0);

      wait_done();
      ptag = "";
      repeat (3) @(negedge clk);
      for (int i = 0; i < NB; i++)
         peek(i, int'(marks[i]) | int'(i == 5 || i == 9),
              (i == 5 || i == 9) ? "R8" : "R2");
      #1;
      chk("R5", "pe_grant after walk", int'(pe_grant), 1);

      // run-time failure
      ptag = "R6";
      @(negedge clk); sfail_vld = 1'b1; sfail_blk = 4'd2;
      @(negedge clk); sfail_vld = 1'b0; q_blk = 4'd2;
      #1;
      chk("R6", "entry 2 after failure", int'(q_bad), 1);

      // rebuild with a changed array and a full failure queue
      foreach (marks[i]) marks[i] = (i == 1 || i == 4 || i == 7 || i == 11);
      seed = 1;
      ptag = "R7";
      @(negedge clk); rebuild_req = 1'b1;
      @(negedge clk); rebuild_req = 1'b0;
      #1;
      chk("R7", "scan_done after rebuild", int'(scan_done), 0);
      chk("R7", "walk restart block", int'(mrd_blk), 0);
      @(negedge clk); sfail_vld = 1'b1; sfail_blk = 4'd3;
      @(negedge clk); sfail_blk = 4'd6;
      @(negedge clk); sfail_blk = 4'd10;
      @(negedge clk); sfail_blk = 4'd12;
      @(negedge clk); sfail_vld = 1'b0;
      pe_req = 1'b0;
      wait_done();
      ptag = "";
      repeat (6) @(negedge clk);
      for (int i = 0; i < NB; i++)
         peek(i, int'(marks[i]) | int'(i == 3 || i == 6 || i == 10 || i == 12),
              (i == 3 || i == 6 || i == 10 || i == 12) ? "R8" : "R7");

      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule